// File: doc/BRIEF.md
# Crosspoint Routing Configuration Controller

This block holds the routing state of a 68-by-68 crosspoint and applies it to a combinational array of 68 one-bit selectors, one per output, plus a 69th selector that taps any input for activity monitoring. Each output owns a 7-bit select register naming one input, or a reserved code that forces the output low. The selectors carry no register and no clock, so data at any rate or phase passes straight through.

A host programs the routing through one command port with three formats, picked by the `mode` input. In serial format a 14-bit frame is shifted in and committed on a load strobe. In output-addressed parallel format one output is named per write. In burst format one input is fanned out to all outputs over four writes. Every select has a pending and an active copy. With queueing off a write lands in both and takes effect at the next clock edge. With queueing on writes collect in the pending copy until a configure strobe moves the whole pending set into the active set in one clock.

Reset and the active-low init input both load a straight-through map. Malformed commands are dropped and reported by a one-cycle error pulse.

Top module: `xpt_cfg_ctrl`

## Requirements
- R1: Each output `data_out[o]` equals `data_in[s]` in the same cycle, where `s` in 0..67 is the active select of output o. There is no clock on this path.
- R2: Reset, or `init_n` low at a clock edge, loads both the active and the pending copy with the straight-through map: output n takes input n, and the monitor takes input 0. `init_n` overrides any write or strobe made in the same cycle.
- R3: Select code 7'h7F disables an output, which then drives 0.
- R4: A select code from 68 to 126, or a non-burst address above 68, drops the write. `err` is high for exactly the one cycle after that command. Valid commands leave `err` low.
- R5: With `mode` = 2'd1, `par_wr` writes `par_sel` to the output numbered `par_addr`.
- R6: With `mode` = 2'd0, each clock with `ser_shift` high shifts `ser_din` into a 14-bit frame, MSB first: bits 13..7 are the address and bits 6..0 are the select. The frame is committed on the clock where `ser_load` is first seen high.
- R7: With `mode` = 2'd2, successive valid `burst_wr` writes set outputs 0-16, then 17-33, then 34-50, then 51-67 to `burst_sel`, and the sequence then wraps. An invalid burst code does not advance the sequence. Init restarts the sequence at outputs 0-16.
- R8: With `queue_en` high, writes change only the pending copy. A one-cycle `cfg_strobe` copies every pending select, including the monitor select, into the active copy at one clock edge.
- R9: With `queue_en` low, a write changes the active select at the same edge, so the new route shows once that edge has passed.
- R10: Address 68 names the monitor select. `mon_out` follows the selected input, or drives 0 when the monitor select holds 7'h7F.
- R11: Commands of any format other than the one `mode` selects are ignored, and mode 2'd3 accepts nothing. Serial bits are not shifted, and a load edge does not commit, outside mode 2'd0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_n | input | 1 | Synchronous active-low load of the straight-through map |
| mode | input | 2 | Command format: 0 serial, 1 output-addressed, 2 burst, 3 none |
| queue_en | input | 1 | Stage writes in the pending copy only |
| cfg_strobe | input | 1 | Copy the pending copy to the active copy |
| ser_shift | input | 1 | Shift enable for the serial frame |
| ser_din | input | 1 | Serial frame bit |
| ser_load | input | 1 | Serial commit strobe, acting on its rising edge |
| par_wr | input | 1 | Output-addressed write strobe |
| par_addr | input | 7 | Output address, where 68 is the monitor |
| par_sel | input | 7 | Select code for the addressed output |
| burst_wr | input | 1 | Burst write strobe |
| burst_sel | input | 7 | Input fanned out to the current output group |
| data_in | input | 68 | Crosspoint data inputs |
| data_out | output | 68 | Crosspoint data outputs |
| mon_out | output | 1 | Monitor selector output |
| err | output | 1 | One-cycle pulse after a dropped command |

## Verification
The assertions assume that at most one command arrives per clock, that `cfg_strobe` and `init_n` are single clean levels at each edge, and that `data_in` only changes away from the clock edge. Without these, a route checked at an edge could still be settling. The bench holds every control input low between commands and drives all inputs on the falling edge. It sweeps `data_in` one-hot across all 68 inputs only while no command is pending, so every route is compared against a model that changes only at the edges where the requirements say it should.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   typedef enum logic [1:0] {
      MODE_SERIAL = 2'd0,
      MODE_PADDR  = 2'd1,
      MODE_BURST  = 2'd2,
      MODE_IDLE   = 2'd3
   } xpt_mode_e;

   // Straight-through home code of a select slot; slot n_out is the monitor.
   function automatic int home_code(input int slot, input int n_in, input int n_out,
                                    input int dis);
      if (slot == n_out) return 0;
      else if (slot < n_in) return slot;
      else return dis;
   endfunction
endpackage

// File: rtl/xpt_serial_rx.sv
module xpt_serial_rx #(
   parameter int FRAME_W = 14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               shift_en,
   input  logic               din,
   input  logic               load,
   output logic [FRAME_W-1:0] frame,
   output logic               frame_vld
);
   timeunit 1ns;
   timeprecision 1ps;

   logic [FRAME_W-1:0] sreg;
   logic               load_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg   <= '0;
         load_q <= 1'b0;
      end else begin
         if (shift_en) sreg <= {sreg[FRAME_W-2:0], din};
         load_q <= load;
      end
   end

   assign frame     = sreg;
   assign frame_vld = load && !load_q;

   // R6: a held load strobe commits only once
   p_load_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_vld |=> !frame_vld);
endmodule

// File: rtl/xpt_cmd_dec.sv
module xpt_cmd_dec
   import xpt_pkg::*;
#(
   parameter int N_IN         = 68,
   parameter int N_OUT        = 68,
   parameter int SEL_W        = 7,
   parameter int BURST_CYCLES = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               init_n,
   input  xpt_mode_e          mode,
   input  logic               frm_vld,
   input  logic [2*SEL_W-1:0] frm,
   input  logic               par_wr,
   input  logic [SEL_W-1:0]   par_addr,
   input  logic [SEL_W-1:0]   par_sel,
   input  logic               burst_wr,
   input  logic [SEL_W-1:0]   burst_sel,
   output logic [N_OUT:0]     wr_mask,
   output logic [SEL_W-1:0]   wr_sel,
   output logic               err
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int GRP   = N_OUT / BURST_CYCLES;
   localparam int CNT_W = $clog2(BURST_CYCLES);
   localparam logic [SEL_W-1:0] NIN_C  = SEL_W'(N_IN);
   localparam logic [SEL_W-1:0] NOUT_C = SEL_W'(N_OUT);
   localparam logic [SEL_W-1:0] DIS_C  = '1;
   localparam logic [CNT_W-1:0] LAST_C = CNT_W'(BURST_CYCLES - 1);

   logic [CNT_W-1:0] grp_cnt;
   logic             cmd_vld, is_burst, code_ok, addr_ok, accept, bad;
   logic [SEL_W-1:0] cmd_addr, cmd_sel;
   logic [N_OUT:0]   hit;

   always_comb begin
      cmd_vld  = 1'b0;
      is_burst = 1'b0;
      cmd_addr = '0;
      cmd_sel  = '0;
      unique case (mode)
         MODE_SERIAL: begin
            cmd_vld  = frm_vld;
            cmd_addr = frm[2*SEL_W-1:SEL_W];
            cmd_sel  = frm[SEL_W-1:0];
         end
         MODE_PADDR: begin
            cmd_vld  = par_wr;
            cmd_addr = par_addr;
            cmd_sel  = par_sel;
         end
         MODE_BURST: begin
            cmd_vld  = burst_wr;
            is_burst = 1'b1;
            cmd_sel  = burst_sel;
         end
         default: cmd_vld = 1'b0;
      endcase
   end

   assign code_ok = (cmd_sel < NIN_C) || (cmd_sel == DIS_C);
   assign addr_ok = is_burst || (cmd_addr <= NOUT_C);
   assign accept  = cmd_vld && code_ok && addr_ok;
   assign bad     = cmd_vld && !(code_ok && addr_ok);

   for (genvar o = 0; o <= N_OUT; o++) begin : g_hit
      if (o < N_OUT) begin : g_port
         assign hit[o] = is_burst ? (grp_cnt == CNT_W'(o / GRP))
                                  : (cmd_addr == SEL_W'(o));
      end else begin : g_mon
         assign hit[o] = !is_burst && (cmd_addr == NOUT_C);
      end
   end

   assign wr_mask = {(N_OUT+1){accept}} & hit;
   assign wr_sel  = cmd_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grp_cnt <= '0;
         err     <= 1'b0;
      end else begin
         err <= bad;
         if (!init_n)
            grp_cnt <= '0;
         else if (accept && is_burst)
            grp_cnt <= (grp_cnt == LAST_C) ? '0 : grp_cnt + 1'b1;
      end
   end

   // R7: a burst write covers exactly one group of outputs
   p_burst_span_r7: assert property (@(posedge clk) disable iff (!rst_n)
      accept && is_burst |-> $countones(wr_mask) == GRP);
   // R5: an addressed write touches exactly one slot
   p_one_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
      accept && !is_burst |-> $onehot(wr_mask));
endmodule

// File: rtl/xpt_cfg_bank.sv
module xpt_cfg_bank
   import xpt_pkg::*;
#(
   parameter int N_IN  = 68,
   parameter int N_OUT = 68,
   parameter int SEL_W = 7
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        init_n,
   input  logic                        queue_en,
   input  logic                        cfg_strobe,
   input  logic [N_OUT:0]              wr_mask,
   input  logic [SEL_W-1:0]            wr_sel,
   output logic [N_OUT:0][SEL_W-1:0]   act_sel
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int DIS = (1 << SEL_W) - 1;

   logic [N_OUT:0][SEL_W-1:0] pend_sel;

   for (genvar o = 0; o <= N_OUT; o++) begin : g_slot
      localparam logic [SEL_W-1:0] HOME = SEL_W'(home_code(o, N_IN, N_OUT, DIS));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_sel[o] <= HOME;
            act_sel[o]  <= HOME;
         end else if (!init_n) begin
            pend_sel[o] <= HOME;
            act_sel[o]  <= HOME;
         end else begin
            if (wr_mask[o]) pend_sel[o] <= wr_sel;
            if (wr_mask[o] && !queue_en) act_sel[o] <= wr_sel;
            else if (cfg_strobe)         act_sel[o] <= pend_sel[o];
         end
      end

      // R8: with queueing on and no strobe, the active select holds
      p_queue_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
         init_n && queue_en && !cfg_strobe |=> $stable(act_sel[o]));
      // R8: a strobe moves the previous pending select into the active copy
      p_strobe_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
         init_n && cfg_strobe && !(wr_mask[o] && !queue_en)
         |=> act_sel[o] == $past(pend_sel[o]));
      // R9: a direct write leaves both copies equal
      p_direct_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
         init_n && !queue_en && wr_mask[o] |=> act_sel[o] == pend_sel[o]);
      // R2: init restores the home code in both copies
      p_init_home_r2: assert property (@(posedge clk) disable iff (!rst_n)
         !init_n |=> act_sel[o] == HOME && pend_sel[o] == HOME);
   end
endmodule

// File: rtl/xpt_mux_array.sv
module xpt_mux_array #(
   parameter int N_IN  = 68,
   parameter int N_OUT = 68,
   parameter int SEL_W = 7
) (
   input  logic [N_IN-1:0]             data_in,
   input  logic [N_OUT:0][SEL_W-1:0]   act_sel,
   output logic [N_OUT-1:0]            data_out,
   output logic                        mon_out
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam logic [SEL_W-1:0] NIN_C = SEL_W'(N_IN);

   logic [N_OUT:0] slot_out;

   for (genvar o = 0; o <= N_OUT; o++) begin : g_sel
      assign slot_out[o] = (act_sel[o] < NIN_C) ? data_in[act_sel[o]] : 1'b0;
   end

   assign data_out = slot_out[N_OUT-1:0];
   assign mon_out  = slot_out[N_OUT];
endmodule

// File: rtl/xpt_cfg_ctrl.sv
module xpt_cfg_ctrl
   import xpt_pkg::*;
#(
   parameter int N_IN         = 68,
   parameter int N_OUT        = 68,
   parameter int SEL_W        = 7,
   parameter int BURST_CYCLES = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               init_n,
   input  logic [1:0]         mode,
   input  logic               queue_en,
   input  logic               cfg_strobe,
   input  logic               ser_shift,
   input  logic               ser_din,
   input  logic               ser_load,
   input  logic               par_wr,
   input  logic [SEL_W-1:0]   par_addr,
   input  logic [SEL_W-1:0]   par_sel,
   input  logic               burst_wr,
   input  logic [SEL_W-1:0]   burst_sel,
   input  logic [N_IN-1:0]    data_in,
   output logic [N_OUT-1:0]   data_out,
   output logic               mon_out,
   output logic               err
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int FRAME_W = 2 * SEL_W;
   localparam logic [SEL_W-1:0] DIS_C = '1;
   localparam logic [SEL_W-1:0] NIN_C = SEL_W'(N_IN);

   if (BURST_CYCLES < 2)                 begin : g_chk_bc  $error("BURST_CYCLES must be at least 2"); end
   if (N_OUT % BURST_CYCLES != 0)        begin : g_chk_grp $error("N_OUT must divide into BURST_CYCLES groups"); end
   if (N_IN >= (1 << SEL_W) - 1)         begin : g_chk_in  $error("SEL_W too narrow for N_IN plus the disable code"); end
   if (N_OUT >= (1 << SEL_W) - 1)        begin : g_chk_out $error("SEL_W too narrow to address the monitor slot"); end

   xpt_mode_e                  mode_e;
   logic                       shift_en;
   logic [FRAME_W-1:0]         frame;
   logic                       frame_vld;
   logic [N_OUT:0]             wr_mask;
   logic [SEL_W-1:0]           wr_sel;
   logic [N_OUT:0][SEL_W-1:0]  act_sel;

   assign mode_e   = xpt_mode_e'(mode);
   assign shift_en = ser_shift && (mode_e == MODE_SERIAL);

   xpt_serial_rx #(.FRAME_W(FRAME_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(ser_din),
      .load(ser_load), .frame(frame), .frame_vld(frame_vld)
   );

   xpt_cmd_dec #(.N_IN(N_IN), .N_OUT(N_OUT), .SEL_W(SEL_W), .BURST_CYCLES(BURST_CYCLES)) u_dec (
      .clk(clk), .rst_n(rst_n), .init_n(init_n), .mode(mode_e),
      .frm_vld(frame_vld), .frm(frame),
      .par_wr(par_wr), .par_addr(par_addr), .par_sel(par_sel),
      .burst_wr(burst_wr), .burst_sel(burst_sel),
      .wr_mask(wr_mask), .wr_sel(wr_sel), .err(err)
   );

   xpt_cfg_bank #(.N_IN(N_IN), .N_OUT(N_OUT), .SEL_W(SEL_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .init_n(init_n), .queue_en(queue_en),
      .cfg_strobe(cfg_strobe), .wr_mask(wr_mask), .wr_sel(wr_sel),
      .act_sel(act_sel)
   );

   xpt_mux_array #(.N_IN(N_IN), .N_OUT(N_OUT), .SEL_W(SEL_W)) u_mux (
      .data_in(data_in), .act_sel(act_sel), .data_out(data_out), .mon_out(mon_out)
   );

   for (genvar o = 0; o < N_OUT; o++) begin : g_chk_port
      // R1: a valid select routes its input to the output
      p_route_r1: assert property (@(posedge clk) disable iff (!rst_n)
         act_sel[o] < NIN_C |-> data_out[o] == data_in[act_sel[o]]);
      // R3: a disabled output stays low
      p_disable_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
         act_sel[o] == DIS_C |-> !data_out[o]);
   end

   // R10: the monitor follows its own select
   p_mon_route_r10: assert property (@(posedge clk) disable iff (!rst_n)
      act_sel[N_OUT] < NIN_C |-> mon_out == data_in[act_sel[N_OUT]]);
   // R4: a flagged command changed no active select
   p_err_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      err && $past(init_n) && !$past(cfg_strobe) |-> $stable(act_sel));
endmodule

// File: tb/sim_xpt_cfg_ctrl.sv
module sim_xpt_cfg_ctrl;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int NI  = 68;
   localparam int NO  = 68;
   localparam int SW  = 7;
   localparam int DIS = 127;
   localparam int GRP = 17;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0, init_n = 1'b1;
   logic [1:0]    mode = 2'd1;
   logic          queue_en = 1'b0, cfg_strobe = 1'b0;
   logic          ser_shift = 1'b0, ser_din = 1'b0, ser_load = 1'b0;
   logic          par_wr = 1'b0, burst_wr = 1'b0;
   logic [SW-1:0] par_addr = '0, par_sel = '0, burst_sel = '0;
   logic [NI-1:0] data_in = '0;
   logic [NO-1:0] data_out;
   logic          mon_out, err;

   int checks = 0, errors = 0;
   int exp_act [0:NO];
   int exp_pend[0:NO];
   int bcnt = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   xpt_cfg_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .init_n(init_n), .mode(mode), .queue_en(queue_en),
      .cfg_strobe(cfg_strobe), .ser_shift(ser_shift), .ser_din(ser_din), .ser_load(ser_load),
      .par_wr(par_wr), .par_addr(par_addr), .par_sel(par_sel),
      .burst_wr(burst_wr), .burst_sel(burst_sel),
      .data_in(data_in), .data_out(data_out), .mon_out(mon_out), .err(err)
   );

   // ---------------- model ----------------
   task automatic model_home();
      for (int o = 0; o <= NO; o++) begin
         exp_act[o]  = (o == NO) ? 0 : o;
         exp_pend[o] = exp_act[o];
      end
      bcnt = 0;
   endtask

   task automatic model_write(int slot, int code);
      exp_pend[slot] = code;
      if (!queue_en) exp_act[slot] = code;
   endtask

   task automatic model_strobe();
      for (int o = 0; o <= NO; o++) exp_act[o] = exp_pend[o];
   endtask

   // ---------------- checks ----------------
   task automatic check_bit(string req, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic check_routing(string req);
      logic [NO-1:0] exp_o;
      logic          exp_m;
      bit            bad = 1'b0;
      checks++;
      for (int i = 0; i <= NI + 1; i++) begin
         if (i < NI) begin
            data_in = '0;
            data_in[i] = 1'b1;
         end else begin
            data_in = (i == NI) ? '1 : '0;
         end
         #1;
         for (int o = 0; o < NO; o++)
            exp_o[o] = (i < NI) ? (exp_act[o] == i) : ((i == NI) && exp_act[o] < NI);
         exp_m = (i < NI) ? (exp_act[NO] == i) : ((i == NI) && exp_act[NO] < NI);
         if (!bad && (data_out !== exp_o || mon_out !== exp_m)) begin
            bad = 1'b1;
            errors++;
            $display("FAIL %s: pattern %0d actual out=%h mon=%b expected out=%h mon=%b",
                     req, i, data_out, mon_out, exp_o, exp_m);
         end
      end
      data_in = '0;
   endtask

   // ---------------- drivers ----------------
   task automatic par_write(int a, int s);
      @(negedge clk);
      par_wr = 1'b1; par_addr = SW'(a); par_sel = SW'(s);
      @(negedge clk);
      par_wr = 1'b0;
   endtask

   task automatic burst_write(int s);
      @(negedge clk);
      burst_wr = 1'b1; burst_sel = SW'(s);
      @(negedge clk);
      burst_wr = 1'b0;
   endtask

   task automatic ser_bits(logic [2*SW-1:0] f);
      for (int b = 2*SW-1; b >= 0; b--) begin
         @(negedge clk);
         ser_shift = 1'b1; ser_din = f[b];
      end
      @(negedge clk);
      ser_shift = 1'b0;
   endtask

   task automatic ser_pulse();
      @(negedge clk);
      ser_load = 1'b1;
      @(negedge clk);
      @(negedge clk);
      ser_load = 1'b0;
   endtask

   task automatic strobe();
      @(negedge clk);
      cfg_strobe = 1'b1;
      @(negedge clk);
      cfg_strobe = 1'b0;
      model_strobe();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      model_home();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_routing("R2 reset map");
      check_bit("R4 err idle after reset", err, 1'b0);

      // R5 and R9: output-addressed writes
      par_write(0, 3); model_write(0, 3);
      data_in = '0; data_in[3] = 1'b1; #1;
      check_bit("R9 write visible after one edge", data_out[0], 1'b1);
      data_in = '0;
      for (int o = 1; o < NO; o++) begin
         par_write(o, (o * 5 + 3) % NI); model_write(o, (o * 5 + 3) % NI);
      end
      check_routing("R5 addressed sweep");
      par_write(7, DIS);  model_write(7, DIS);
      par_write(20, DIS); model_write(20, DIS);
      par_write(NO, 45);  model_write(NO, 45);
      check_routing("R3 R10 disable and monitor");
      check_bit("R4 err low on valid write", err, 1'b0);

      // R4: invalid codes and addresses
      par_write(3, 70);
      check_bit("R4 err after bad code", err, 1'b1);
      @(negedge clk);
      check_bit("R4 err one cycle", err, 1'b0);
      par_write(90, 5);
      check_bit("R4 err after bad address", err, 1'b1);
      par_write(NO, 68);
      check_bit("R4 err bad monitor code", err, 1'b1);
      check_routing("R4 dropped writes");

      // R11: commands of other formats are ignored
      mode = 2'd2;
      par_write(0, 9);
      mode = 2'd3;
      burst_write(9);
      par_write(3, 70);
      check_bit("R11 no err in idle mode", err, 1'b0);
      check_routing("R11 foreign commands ignored");

      // R6: serial frames
      mode = 2'd0;
      for (int k = 0; k < 10; k++) begin
         ser_bits({SW'(k * 6), SW'(67 - k)}); ser_pulse(); model_write(k * 6, 67 - k);
      end
      ser_bits({SW'(NO), SW'(12)}); ser_pulse(); model_write(NO, 12);
      check_routing("R6 serial frames");
      ser_bits({SW'(30), SW'(1)});
      mode = 2'd1;
      ser_bits(14'h2AAA);
      ser_pulse();
      check_routing("R11 serial ignored in mode 1");
      mode = 2'd0;
      ser_pulse(); model_write(30, 1);
      check_routing("R6 R11 held frame commits");
      ser_bits({SW'(5), SW'(100)});
      @(negedge clk); ser_load = 1'b1;
      @(negedge clk);
      check_bit("R4 serial bad code", err, 1'b1);
      ser_load = 1'b0;

      // R7: burst fan-out
      mode = 2'd2;
      for (int g = 0; g < 4; g++) begin
         burst_write(11);
         for (int o = g * GRP; o < (g + 1) * GRP; o++) model_write(o, 11);
         check_routing("R7 burst group");
      end
      burst_write(100);
      check_bit("R7 R4 bad burst code", err, 1'b1);
      burst_write(5);
      for (int o = 0; o < GRP; o++) model_write(o, 5);
      burst_write(DIS);
      for (int o = GRP; o < 2 * GRP; o++) model_write(o, DIS);
      check_routing("R7 wrap and disable");

      // R8: queued updates
      queue_en = 1'b1; mode = 2'd1;
      par_write(0, 60); model_write(0, 60);
      par_write(NO, 2); model_write(NO, 2);
      check_routing("R8 queued writes held");
      strobe();
      check_routing("R8 strobe applies");
      mode = 2'd2;
      burst_write(33);
      for (int o = 2 * GRP; o < 3 * GRP; o++) model_write(o, 33);
      check_routing("R8 queued burst held");
      strobe();
      check_routing("R8 queued burst applied");
      mode = 2'd1;
      par_write(1, 1); model_write(1, 1);
      queue_en = 1'b0;
      par_write(2, 2); model_write(2, 2);
      check_routing("R9 direct write with pending left");
      strobe();
      check_routing("R8 leftover pending applied");

      // R2: init overrides pending state and restarts burst
      queue_en = 1'b1; mode = 2'd1;
      par_write(4, 9); model_write(4, 9);
      @(negedge clk); init_n = 1'b0;
      @(negedge clk); init_n = 1'b1;
      model_home();
      check_routing("R2 init map");
      strobe();
      check_routing("R2 init cleared pending");
      queue_en = 1'b0; mode = 2'd2;
      burst_write(40);
      for (int o = 0; o < GRP; o++) model_write(o, 40);
      check_routing("R7 R2 burst restarts after init");

      finish_run();
   end
endmodule